// File: doc/BRIEF.md
# Per-Channel Ring Buffer Address Mapper

This block turns a channel number into a physical DRAM byte address for packet-sized transfers. Every channel owns one contiguous window of DRAM, given by a base and a limit address. Inside that window the channel behaves as a circular queue: a pair of offsets marks where the next packet is written and where the oldest stored packet sits. Many independent queues share one DRAM this way, and each wraps at the bound of its own window.

A packet engine issues a request with a channel number and a direction. For a write, the block returns the address at which to store the incoming packet and advances the write offset. For a read, it returns the address of the oldest packet and advances the read offset. Every response also carries the channel's empty and full status. A write to a full queue, or a read from an empty one, is refused with an error flag. Windows are loaded through a configuration port indexed by channel. DRAM command sequencing belongs to a separate block.

Top module: `ringmap_top`

## Requirements
- R1: After reset every channel has base, limit, read offset and write offset all zero, and `rsp_ack` is low.
- R2: A configuration write (`cfg_we` high) stores `cfg_base` and `cfg_limit` for channel `cfg_ch` and sets both of that channel's offsets to zero. No other channel changes.
- R3: An accepted write request returns `rsp_addr` = base + write offset. The write offset then advances by one packet of `PKT_BYTES` bytes (default 192).
- R4: An accepted read request returns `rsp_addr` = base + read offset. The read offset then advances by one packet.
- R5: When an offset plus one packet is greater than or equal to the window size (limit minus base), the offset wraps to zero instead.
- R6: A queue is empty when its read and write offsets are equal. It is full when the advanced write offset would equal the read offset. A write to a full queue, or a read from an empty queue, sets `rsp_err`, returns `rsp_addr` = 0 and changes no state.
- R7: `rsp_ack` is high exactly in the cycle after a request was sampled with `req_valid` high and `cfg_we` low. A request sampled in the same cycle as a configuration write is dropped: it gets no ack and does not move any offset.
- R8: `rsp_empty` and `rsp_full` give the channel's state after the request is applied. A successful write never reports empty, and a successful read never reports full.
- R9: A channel whose window size is zero, including one that was never configured, refuses both reads and writes.
- R10: A request issued in the cycle right after a response for the same channel sees the offsets that response left behind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Load the window of one channel |
| cfg_ch | input | CH_W | Channel to configure |
| cfg_base | input | ADDR_W | First byte address of the window |
| cfg_limit | input | ADDR_W | Address just past the window |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write a packet, 0 = read a packet |
| req_ch | input | CH_W | Channel of the request |
| rsp_ack | output | 1 | Response valid, one cycle after the request |
| rsp_err | output | 1 | Request refused (full on write, empty on read) |
| rsp_addr | output | ADDR_W | DRAM byte address of the packet |
| rsp_empty | output | 1 | Channel is empty after the access |
| rsp_full | output | 1 | Channel is full after the access |

## Verification
The bench steers offsets onto the window bound so that both exact-fit wrap and wrap-to-zero are exercised. A design with an off-by-one in the compare would address one packet past the window, or would skip slot zero. It fills queues until they refuse writes and drains them until they refuse reads. A wrong full test shows up as an overwrite of unread data, and a wrong empty test shows up as a read of a stale slot. Back-to-back requests on one channel catch a design that answers from a stale record. Requests issued during a configuration write, requests to channels that were never loaded, and the highest channel index all check that only the addressed record is touched. Random traffic across mixed window sizes is compared against a bench model throughout.

// File: rtl/ringmap_pkg.sv
package ringmap_pkg;
    localparam int ADDR_W = 29;

    typedef logic [ADDR_W-1:0] addr_t;

    typedef struct packed {
        addr_t base;
        addr_t limit;
        addr_t rd_off;
        addr_t wr_off;
    } chan_rec_t;

    typedef struct packed {
        logic  ack;
        logic  err;
        addr_t addr;
        logic  empty;
        logic  full;
    } rsp_t;
endpackage

// File: rtl/ringmap_step.sv
module ringmap_step
    import ringmap_pkg::*;
#(
    parameter int PKT_BYTES = 192
) (
    input  addr_t off,
    input  addr_t size,
    output addr_t nxt
);
    localparam int SUM_W = ADDR_W + 1;

    logic [SUM_W-1:0] sum;

    always_comb begin
        sum = {1'b0, off} + SUM_W'(PKT_BYTES);
        if (sum >= {1'b0, size}) begin
            nxt = '0;
        end else begin
            nxt = sum[ADDR_W-1:0];
        end
    end
endmodule

// File: rtl/ringmap_table.sv
module ringmap_table
    import ringmap_pkg::*;
#(
    parameter int NUM_CH = 512,
    localparam int CH_W  = $clog2(NUM_CH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [CH_W-1:0] wr_ch,
    input  chan_rec_t       wr_rec,
    input  logic [CH_W-1:0] rd_ch,
    output chan_rec_t       rd_rec
);
    chan_rec_t mem_d [NUM_CH];
    chan_rec_t mem_q [NUM_CH];

    always_comb begin
        mem_d = mem_q;
        if (wr_en) begin
            mem_d[wr_ch] = wr_rec;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_CH; i++) begin
                mem_q[i] <= '0;
            end
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rd_rec = mem_q[rd_ch];
endmodule

// File: rtl/ringmap_top.sv
module ringmap_top
    import ringmap_pkg::*;
#(
    parameter int NUM_CH    = 512,
    parameter int PKT_BYTES = 192,
    localparam int CH_W     = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CH_W-1:0]   cfg_ch,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic [ADDR_W-1:0] cfg_limit,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [CH_W-1:0]   req_ch,
    output logic              rsp_ack,
    output logic              rsp_err,
    output logic [ADDR_W-1:0] rsp_addr,
    output logic              rsp_empty,
    output logic              rsp_full
);
    localparam int N_STEP = 3;

    chan_rec_t        cur;
    chan_rec_t        upd;
    logic             tbl_we;
    logic [CH_W-1:0]  tbl_ch;
    addr_t            size;
    addr_t            step_in  [N_STEP];
    addr_t            step_out [N_STEP];
    rsp_t             rsp_d, rsp_q;
    logic             is_empty, is_full;

    ringmap_table #(.NUM_CH(NUM_CH)) u_table (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (tbl_we),
        .wr_ch  (tbl_ch),
        .wr_rec (upd),
        .rd_ch  (req_ch),
        .rd_rec (cur)
    );

    assign size       = cur.limit - cur.base;
    assign step_in[0] = cur.rd_off;
    assign step_in[1] = cur.wr_off;
    assign step_in[2] = step_out[1];

    for (genvar g = 0; g < N_STEP; g++) begin : g_step
        ringmap_step #(.PKT_BYTES(PKT_BYTES)) u_step (
            .off  (step_in[g]),
            .size (size),
            .nxt  (step_out[g])
        );
    end

    assign is_empty = (cur.rd_off == cur.wr_off);
    assign is_full  = (step_out[1] == cur.rd_off);

    always_comb begin
        rsp_d  = '0;
        upd    = cur;
        tbl_we = 1'b0;
        tbl_ch = req_ch;
        if (cfg_we) begin
            tbl_we     = 1'b1;
            tbl_ch     = cfg_ch;
            upd        = '0;
            upd.base   = cfg_base;
            upd.limit  = cfg_limit;
        end else if (req_valid) begin
            rsp_d.ack = 1'b1;
            if (req_write) begin
                if (is_full) begin
                    rsp_d.err   = 1'b1;
                    rsp_d.empty = is_empty;
                    rsp_d.full  = 1'b1;
                end else begin
                    rsp_d.addr  = cur.base + cur.wr_off;
                    upd.wr_off  = step_out[1];
                    tbl_we      = 1'b1;
                    rsp_d.empty = 1'b0;
                    rsp_d.full  = (step_out[2] == cur.rd_off);
                end
            end else begin
                if (is_empty) begin
                    rsp_d.err   = 1'b1;
                    rsp_d.empty = 1'b1;
                    rsp_d.full  = is_full;
                end else begin
                    rsp_d.addr  = cur.base + cur.rd_off;
                    upd.rd_off  = step_out[0];
                    tbl_we      = 1'b1;
                    rsp_d.empty = (step_out[0] == cur.wr_off);
                    rsp_d.full  = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_ack   = rsp_q.ack;
    assign rsp_err   = rsp_q.err;
    assign rsp_addr  = rsp_q.addr;
    assign rsp_empty = rsp_q.empty;
    assign rsp_full  = rsp_q.full;
endmodule

// File: rtl/ringmap_check.sv
module ringmap_check (
    input logic clk,
    input logic rst_n,
    input logic cfg_we,
    input logic req_valid,
    input logic req_write,
    input logic rsp_ack,
    input logic rsp_err,
    input logic rsp_empty,
    input logic rsp_full
);
    a_r7_ack_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !cfg_we) |=> rsp_ack);

    a_r7_no_spurious_ack: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && !cfg_we) |=> !rsp_ack);

    a_r6_err_has_ack: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> rsp_ack);

    a_r8_write_not_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !cfg_we && req_write) |=> (rsp_err || !rsp_empty));

    a_r8_read_not_full: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !cfg_we && !req_write) |=> (rsp_err || !rsp_full));

    a_r6_read_err_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !cfg_we && !req_write) |=> (!rsp_err || rsp_empty));
endmodule

bind ringmap_top ringmap_check u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .req_valid (req_valid),
    .req_write (req_write),
    .rsp_ack   (rsp_ack),
    .rsp_err   (rsp_err),
    .rsp_empty (rsp_empty),
    .rsp_full  (rsp_full)
);

// File: tb/ringmap_top_test.sv
module ringmap_top_test;
    localparam int NUM_CH = 512;
    localparam int CH_W   = 9;
    localparam int AW     = 29;
    localparam int PKT    = 192;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [CH_W-1:0] cfg_ch = '0;
    logic [AW-1:0] cfg_base = '0;
    logic [AW-1:0] cfg_limit = '0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [CH_W-1:0] req_ch = '0;
    logic          rsp_ack, rsp_err, rsp_empty, rsp_full;
    logic [AW-1:0] rsp_addr;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    longint m_base [NUM_CH];
    longint m_lim  [NUM_CH];
    longint m_rd   [NUM_CH];
    longint m_wr   [NUM_CH];

    always #2.5 clk = ~clk;

    ringmap_top uut (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_base(cfg_base), .cfg_limit(cfg_limit),
        .req_valid(req_valid), .req_write(req_write), .req_ch(req_ch),
        .rsp_ack(rsp_ack), .rsp_err(rsp_err), .rsp_addr(rsp_addr),
        .rsp_empty(rsp_empty), .rsp_full(rsp_full)
    );

    function automatic longint adv(longint off, longint sz);
        if (off + PKT >= sz) return 0;
        return off + PKT;
    endfunction

    task automatic check(bit ok, string tag, string got, string exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s got=%s exp=%s", tag, got, exp);
        end
    endtask

    task automatic configure(int ch, longint base, longint lim);
        cfg_we    = 1'b1;
        cfg_ch    = CH_W'(ch);
        cfg_base  = AW'(base);
        cfg_limit = AW'(lim);
        @(negedge clk);
        cfg_we = 1'b0;
        m_base[ch] = base; m_lim[ch] = lim; m_rd[ch] = 0; m_wr[ch] = 0;
    endtask

    task automatic request(bit wr, int ch, string tag);
        longint sz, e_addr;
        bit e_err, e_emp, e_full;
        sz = m_lim[ch] - m_base[ch];
        req_valid = 1'b1;
        req_write = wr;
        req_ch    = CH_W'(ch);
        @(negedge clk);
        req_valid = 1'b0;
        e_addr = 0;
        if (wr) begin
            if (adv(m_wr[ch], sz) == m_rd[ch]) begin
                e_err = 1; e_full = 1; e_emp = (m_rd[ch] == m_wr[ch]);
            end else begin
                e_err = 0; e_addr = m_base[ch] + m_wr[ch];
                m_wr[ch] = adv(m_wr[ch], sz);
                e_emp = 0; e_full = (adv(m_wr[ch], sz) == m_rd[ch]);
            end
        end else begin
            if (m_rd[ch] == m_wr[ch]) begin
                e_err = 1; e_emp = 1; e_full = (adv(m_wr[ch], sz) == m_rd[ch]);
            end else begin
                e_err = 0; e_addr = m_base[ch] + m_rd[ch];
                m_rd[ch] = adv(m_rd[ch], sz);
                e_full = 0; e_emp = (m_rd[ch] == m_wr[ch]);
            end
        end
        check(rsp_ack === 1'b1 && rsp_err === e_err && rsp_addr === AW'(e_addr)
              && rsp_empty === e_emp && rsp_full === e_full, tag,
              $sformatf("ack=%b err=%b addr=%0d emp=%b full=%b", rsp_ack, rsp_err, rsp_addr, rsp_empty, rsp_full),
              $sformatf("ack=1 err=%b addr=%0d emp=%b full=%b", e_err, e_addr, e_emp, e_full));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int lst [8] = '{0, 1, 2, 3, 4, 5, 510, 511};
        void'($urandom(32'd1234));
        for (int i = 0; i < NUM_CH; i++) begin
            m_base[i] = 0; m_lim[i] = 0; m_rd[i] = 0; m_wr[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(rsp_ack === 1'b0, "R1 reset ack low", $sformatf("%b", rsp_ack), "0");

        // R9: never configured channel refuses both directions (R1 zero window)
        request(1'b1, 77, "R9 R1 write to unloaded channel");
        request(1'b0, 77, "R9 read from unloaded channel");

        // R3 R4 R5 R6: window of four packets, exact fit wrap
        configure(3, 4096, 4096 + 4*PKT);
        request(1'b0, 3, "R6 read empty after load");
        for (int k = 0; k < 3; k++) request(1'b1, 3, "R3 R10 write back-to-back");
        request(1'b1, 3, "R6 write to full refused");
        request(1'b0, 3, "R4 read oldest");
        request(1'b1, 3, "R5 write wraps tail at bound");
        request(1'b1, 3, "R6 full again");
        for (int k = 0; k < 3; k++) request(1'b0, 3, "R4 R5 drain with wrap");
        request(1'b0, 3, "R6 read empty after drain");

        // R5: window not a multiple of a packet; wrap when offset+pkt passes size
        configure(511, 20000, 20000 + 2*PKT + 10);
        for (int k = 0; k < 3; k++) request(1'b1, 511, "R5 R3 top channel partial window");
        request(1'b1, 511, "R6 top channel full");

        // R2: reload resets offsets, neighbour channel untouched
        configure(3, 4096, 4096 + 4*PKT);
        request(1'b0, 3, "R2 reload empties channel");
        request(1'b1, 511, "R2 neighbour still full");
        request(1'b0, 511, "R2 neighbour keeps data");

        // R9: single-packet window holds nothing
        configure(5, 9000, 9000 + PKT);
        request(1'b1, 5, "R9 one-slot window refuses write");

        // R7: request during configuration write is dropped
        cfg_we = 1'b1; cfg_ch = CH_W'(200); cfg_base = AW'(30000); cfg_limit = AW'(30000 + 3*PKT);
        req_valid = 1'b1; req_write = 1'b1; req_ch = CH_W'(3);
        @(negedge clk);
        cfg_we = 1'b0; req_valid = 1'b0;
        m_base[200] = 30000; m_lim[200] = 30000 + 3*PKT; m_rd[200] = 0; m_wr[200] = 0;
        check(rsp_ack === 1'b0, "R7 request with cfg dropped", $sformatf("%b", rsp_ack), "0");
        request(1'b0, 3, "R7 dropped write left channel empty");
        @(negedge clk);
        check(rsp_ack === 1'b0, "R7 ack only one cycle", $sformatf("%b", rsp_ack), "0");

        // Random traffic over mixed windows
        for (int i = 0; i < 8; i++)
            configure(lst[i], 40000 + i*8192, 40000 + i*8192 + (1 + $urandom_range(0, 5))*PKT);
        for (int n = 0; n < 4000; n++) begin
            int c = lst[$urandom_range(0, 7)];
            request(1'($urandom_range(0, 1)), c, "R3 R4 R6 R8 random traffic");
            if ($urandom_range(0, 40) == 0) @(negedge clk);
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule